// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns raw active-low external interrupt pins into pending flags for an interrupt controller. Each pin first passes through a short synchronizer chain. A per-pin trigger-mode bit then picks how the pending flag behaves. In level mode the flag is the inverted synchronized pin and is never stored. In edge mode a high-to-low transition latches the flag, and the flag stays set until the controller acknowledges the vector or software clears it.

The controller raises a one-cycle vector-taken acknowledge for a pin when it enters that pin's service routine. Software can write a pin's flag through a write strobe and a data bit. The number of pins and the synchronizer depth are parameters. By default there are two channels, and they behave the same but have separate controls.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, with every pin high, every pending flag reads 0.
- R2: With the mode bit at 0 (level), the pending flag equals the inverse of the pin, delayed by exactly SYNC_STAGES clock cycles.
- R3: In level mode the flag is not latched. A vector acknowledge has no effect on it, so a pin that is still low keeps the request raised. A pin that returns high drops the request after SYNC_STAGES cycles.
- R4: With the mode bit at 1 (edge), a high-to-low transition of the pin sets the pending flag SYNC_STAGES+1 cycles after the pin changes.
- R5: In edge mode the flag stays set after the pin returns high.
- R6: In edge mode a vector acknowledge with no coincident falling edge and no software write clears the flag on the next clock edge.
- R7: When a detected falling edge and a vector acknowledge coincide in the same cycle, the flag is set after that edge.
- R8: In edge mode a software write (write strobe 1) loads the data bit into the flag on the next clock edge, so data 1 sets the flag and data 0 clears it. In level mode a software write does not change the flag.
- R9: In edge mode neither a rising edge nor a pin held low sets the flag.
- R10: Changing a channel's mode clears its latched flag. The first cycle after a change detects no edge, so a pin that fell while the channel was in level mode does not set the flag on entry to edge mode.
- R11: Channels are independent. One channel's pin, mode, acknowledge and write never change another channel's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_n | input | NUM_PINS | Raw active-low external interrupt pins, asynchronous |
| edge_mode | input | NUM_PINS | Per-pin trigger select: 1 edge, 0 level |
| vec_ack | input | NUM_PINS | Controller has vectored to this pin's routine (one-cycle pulse) |
| sw_wr | input | NUM_PINS | Software write strobe for the pending flag |
| sw_data | input | NUM_PINS | Value written to the flag when sw_wr is 1 |
| pend | output | NUM_PINS | Pending flags to the interrupt controller |

## Verification
The bound checker runs on every cycle and for each channel. It checks that a level-mode flag always matches the pin delayed by the synchronizer depth. It also checks that an acknowledge alone clears an edge-mode flag, that a detected edge always beats a coincident acknowledge, that an edge-mode flag only rises after a detected fall or a software set, and that entering edge mode starts with the flag clear and with edge detection masked. Some behaviours depend on sequences of stimulus, and only the bench scenarios show them. These are the exact latency of an edge from the pin to the flag, the flag holding after the pin rises, a held-low pin not retriggering, a software write having no effect in level mode, and a fall that happened in level mode not producing a false edge after the switch.

// File: rtl/ext_irq_pkg.sv
// Shared definitions for the external interrupt pin conditioner.
// Assumes: one trigger-mode bit per pin, where 1 selects edge operation.
package ext_irq_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    // Idle (inactive) level of an active-low pin.
    localparam logic PIN_IDLE = 1'b1;

endpackage

// File: rtl/irq_pin_sync.sv
// Multi-stage synchronizer for one raw asynchronous pin.
// Assumes: STAGES >= 2. Every stage resets to the idle (high) level so that
// reset never looks like an asserted request.
module irq_pin_sync
    import ext_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{PIN_IDLE}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_raw};
        end
    end

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_chan.sv
// Pending-flag logic for one synchronized active-low interrupt pin.
// Level mode: the flag is the inverted synchronized pin and is never stored.
// Edge mode: a 1->0 transition latches the flag. The priority is
// edge > software write > acknowledge. A mode change clears the latched flag
// and masks edge detection for one cycle.
// Assumes: pin_s is already synchronized to clk.
module irq_chan
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  trig_mode_e mode,
    input  logic       ack,
    input  logic       wr,
    input  logic       wdata,
    output logic       pend,
    output logic       fall
);

    logic       prev_q;
    trig_mode_e mode_q;
    logic       flag_q;
    logic       flag_d;
    logic       mode_steady;

    // Track the previous synchronized sample and the previous mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= PIN_IDLE;
            mode_q <= TRIG_LEVEL;
        end else begin
            prev_q <= pin_s;
            mode_q <= mode;
        end
    end

    // Edge detection is only trusted once the mode has been stable for a cycle.
    assign mode_steady = (mode == TRIG_EDGE) && (mode_q == TRIG_EDGE);
    assign fall        = mode_steady && prev_q && !pin_s;

    // Next-state choice for the latched edge flag.
    always_comb begin
        flag_d = flag_q;
        if (mode != TRIG_EDGE || mode_q != TRIG_EDGE) begin
            flag_d = 1'b0;
        end else if (fall) begin
            flag_d = 1'b1;
        end else if (wr) begin
            flag_d = wdata;
        end else if (ack) begin
            flag_d = 1'b0;
        end
    end

    // Hold the latched edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // Present either the stored flag or the live inverted pin.
    assign pend = (mode == TRIG_EDGE) ? flag_q : !pin_s;

endmodule

// File: rtl/ext_irq_cond.sv
// Top of the external interrupt pin conditioner: NUM_PINS channels, each
// with its own synchronizer and pending-flag logic.
// Assumes: pins are asynchronous and active-low, and vec_ack is a one-cycle
// pulse from the interrupt controller.
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_n,
    input  logic [NUM_PINS-1:0] edge_mode,
    input  logic [NUM_PINS-1:0] vec_ack,
    input  logic [NUM_PINS-1:0] sw_wr,
    input  logic [NUM_PINS-1:0] sw_data,
    output logic [NUM_PINS-1:0] pend
);

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] fall_det;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chan
        irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (pin_n[g]),
            .pin_sync (pin_sync[g])
        );

        irq_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_sync[g]),
            .mode  (trig_mode_e'(edge_mode[g])),
            .ack   (vec_ack[g]),
            .wr    (sw_wr[g]),
            .wdata (sw_data[g]),
            .pend  (pend[g]),
            .fall  (fall_det[g])
        );
    end

endmodule

// File: rtl/ext_irq_cond_chk.sv
// Property checker for ext_irq_cond, attached with bind. It watches the ports
// and the per-channel falling-edge strobe.
module ext_irq_cond_chk #(
    parameter int NUM_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_n,
    input logic [NUM_PINS-1:0] edge_mode,
    input logic [NUM_PINS-1:0] vec_ack,
    input logic [NUM_PINS-1:0] sw_wr,
    input logic [NUM_PINS-1:0] sw_data,
    input logic [NUM_PINS-1:0] pend,
    input logic [NUM_PINS-1:0] fall_det
);

    localparam int WARM = SYNC_STAGES + 1;
    localparam int CW   = $clog2(WARM + 1) + 1;

    logic [CW-1:0] since_rst;

    // Count cycles since reset release, saturating at the warm-up depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst < CW'(WARM)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R2
        assert_level_tracks_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= CW'(WARM) && !edge_mode[i]) |-> (pend[i] == !$past(pin_n[i], SYNC_STAGES)));

        // R6
        assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= CW'(1) && edge_mode[i] && vec_ack[i] && !sw_wr[i] && !fall_det[i])
            |=> (!edge_mode[i] || !pend[i]));

        // R7
        assert_edge_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[i] && fall_det[i]) |=> (!edge_mode[i] || pend[i]));

        // R9
        assert_rise_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= CW'(2) && edge_mode[i] && $past(edge_mode[i]) && $rose(pend[i]))
            |-> ($past(fall_det[i]) || $past(sw_wr[i] && sw_data[i])));

        // R10
        assert_mode_entry_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= CW'(1) && $rose(edge_mode[i])) |-> (!pend[i] && !fall_det[i]));
    end

endmodule

bind ext_irq_cond ext_irq_cond_chk #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (pin_n),
    .edge_mode (edge_mode),
    .vec_ack   (vec_ack),
    .sw_wr     (sw_wr),
    .sw_data   (sw_data),
    .pend      (pend),
    .fall_det  (fall_det)
);

// File: tb/ext_irq_cond_bench.sv
// Scoreboard bench: the driver pushes expected flag values, and the monitor
// compares them on the falling clock edge.
module ext_irq_cond_bench;

    localparam int N = 2;

    typedef struct {
        int    ch;
        bit    exp;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_n = '1;
    logic [N-1:0] edge_mode = '0;
    logic [N-1:0] vec_ack = '0;
    logic [N-1:0] sw_wr = '0;
    logic [N-1:0] sw_data = '0;
    logic [N-1:0] pend;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    ext_irq_cond #(.NUM_PINS(N), .SYNC_STAGES(2)) u_ext_irq_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_n),
        .edge_mode (edge_mode),
        .vec_ack   (vec_ack),
        .sw_wr     (sw_wr),
        .sw_data   (sw_data),
        .pend      (pend)
    );

    // Monitor: pop every queued expectation and compare it with the output.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (pend[e.ch] !== e.exp) begin
                n_fail++;
                $display("FAIL %s ch%0d: pend=%b expected=%b", e.tag, e.ch, pend[e.ch], e.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_pend(input int ch, input bit v, input string tag);
        exp_t e;
        e.ch = ch; e.exp = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic pulse_ack(input int ch);
        vec_ack[ch] = 1'b1; tick(1); vec_ack[ch] = 1'b0;
    endtask

    task automatic sw_write(input int ch, input bit v);
        sw_wr[ch] = 1'b1; sw_data[ch] = v; tick(1); sw_wr[ch] = 1'b0; sw_data[ch] = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_pend(0, 0, "R1"); expect_pend(1, 0, "R1");

        // Level mode on ch0: exact latency.
        pin_n[0] = 1'b0;
        tick(1); expect_pend(0, 0, "R2 latency");
        tick(1); expect_pend(0, 1, "R2");
        pulse_ack(0); expect_pend(0, 1, "R3 ack ignored");
        pin_n[0] = 1'b1;
        tick(2); expect_pend(0, 0, "R3 not latched");
        sw_write(0, 1); expect_pend(0, 0, "R8 level write ignored");
        tick(1); expect_pend(0, 0, "R8 level write ignored");

        // Edge mode on ch0.
        edge_mode[0] = 1'b1;
        tick(1); expect_pend(0, 0, "R10 entry clear");
        tick(1);
        pin_n[0] = 1'b0;
        tick(2); expect_pend(0, 0, "R4 latency");
        tick(1); expect_pend(0, 1, "R4");
        pin_n[0] = 1'b1;
        tick(3); expect_pend(0, 1, "R5 held");
        pulse_ack(0); expect_pend(0, 0, "R6");
        tick(2); expect_pend(0, 0, "R9 rising");

        // Software write in edge mode.
        sw_write(0, 1); expect_pend(0, 1, "R8 set");
        sw_write(0, 0); expect_pend(0, 0, "R8 clear");

        // Edge and acknowledge in the same cycle.
        sw_write(0, 1);
        pin_n[0] = 1'b0;
        tick(2);
        pulse_ack(0); expect_pend(0, 1, "R7");
        pulse_ack(0); expect_pend(0, 0, "R6 after R7");
        tick(3); expect_pend(0, 0, "R9 held low");
        pin_n[0] = 1'b1;
        tick(3);

        // Mode switch with the flag set.
        pin_n[0] = 1'b0; tick(3); expect_pend(0, 1, "R4 again");
        pin_n[0] = 1'b1; tick(3);
        edge_mode[0] = 1'b0;
        tick(1); expect_pend(0, 0, "R10 to level");
        edge_mode[0] = 1'b1;
        tick(1); expect_pend(0, 0, "R10 flag cleared");
        tick(2);

        // A fall in level mode must not become a false edge.
        edge_mode[0] = 1'b0; tick(2);
        pin_n[0] = 1'b0; tick(2);
        edge_mode[0] = 1'b1;
        tick(1); expect_pend(0, 0, "R10 no false edge");
        tick(2); expect_pend(0, 0, "R10 no false edge");
        pin_n[0] = 1'b1; tick(3);

        // Channel independence.
        edge_mode[0] = 1'b0; tick(1);
        edge_mode[1] = 1'b1; tick(2);
        pin_n[1] = 1'b0;
        tick(3); expect_pend(1, 1, "R11 ch1 set"); expect_pend(0, 0, "R11 ch0 quiet");
        pulse_ack(0); expect_pend(1, 1, "R11 ch0 ack");
        sw_write(0, 0); expect_pend(1, 1, "R11 ch0 write");
        pin_n[0] = 1'b0; tick(2); expect_pend(0, 1, "R11 ch0 level"); expect_pend(1, 1, "R11 ch1 kept");
        pulse_ack(1); expect_pend(1, 0, "R11 ch1 ack"); expect_pend(0, 1, "R11 ch0 kept");
        pin_n = '1;
        tick(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule